// File: doc/BRIEF.md
# Virtual Address Translation Fault Unit

This unit turns a 32-bit virtual address into a physical address for either an instruction fetch or a data access. For addresses in the mapped region it issues a lookup to an external translation buffer. The buffer answers in the same cycle with a hit flag, a page mask, and a frame number, dirty bit and valid bit for each of the two pages of a pair. Two fixed kernel windows bypass the buffer and are mapped to physical memory by clearing the top three address bits.

When a translation cannot complete, the unit reports a fault code. It also presents the fields that a software handler needs to refill the buffer: the faulting address, the address space identifier, the page-pair number, the sub-pair bits and a copy of the page-pair number for the context register. All results are registered, so they appear one clock after the request is presented. The lookup port itself is combinational.

Top module: `xlat_fault_unit`

## Requirements
- R1: `tlb_lookup_o` is high exactly when `va_i[31:30]` is not `2'b10`. `tlb_vpn_o` is `va_i[31:11]` with its two low bits forced to zero unless `small_pages_i` is 1. `tlb_asid_o` follows `asid_i`.
- R2: An address with `va_i[31:29]==3'b100` translates to `va_i` with bits 31..29 cleared. It faults with an address error if `kernel_i` is 0 or `misaligned_i` is 1.
- R3: An address with `va_i[31:29]==3'b101` translates to `va_i` with bits 31..29 cleared. It never faults, whatever the mode, the alignment or the buffer response.
- R4: `fault_o` encodes 0 none, 1 address error on a fetch, 2 address error on a data access, 3 refill on a fetch, 4 refill on a data access, 5 invalid on a fetch, 6 invalid on a data access, 7 modified. `fetch_i`=1 marks a fetch.
- R5: In the mapped region, `misaligned_i` gives an address error (code 1 or 2). This takes priority over every buffer-derived fault.
- R6: The page shift is 12 plus the number of set bits in `tlb_mask_i`, where the mask is contiguous from bit 0. `va_i[shift]`=0 selects the even frame, dirty bit and valid bit; 1 selects the odd ones.
- R7: An aligned mapped access gives a refill fault when `tlb_hit_i` is 0. It gives an invalid fault when there is a hit but the selected valid bit is 0.
- R8: A data store (`fetch_i`=0, `store_i`=1) that hits a valid half whose dirty bit is 0 gives the modified fault. Loads and fetches never do.
- R9: On a successful mapped access, `pa_o` is the selected frame shifted right by (shift−12) and then left by shift, ORed with the `va_i` bits below the shift. `pa_o` is 0 whenever `fault_o` is not 0.
- R10: `uncached_o` is 1 exactly when the access does not fault and `va_i[31]` and `va_i[29]` are both 1.
- R11: On fault codes 3..7 the capture outputs hold the following. `bad_vaddr_o` is the address. `flt_asid_o` is the ASID. `flt_vpn2_o` and `ctx_badvpn2_o` are the lookup VPN shifted right by 2. `flt_vpn2x_o` is the low two bits of the lookup VPN. On codes 1..2 only `bad_vaddr_o` is loaded and the rest are 0. With no fault all capture outputs are 0.
- R12: Every registered output reflects the inputs of the previous clock. While `rst_ni` is low all registered outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| va_i | input | 32 | Virtual address |
| asid_i | input | 8 | Address space identifier |
| kernel_i | input | 1 | Processor in kernel mode |
| misaligned_i | input | 1 | Access is misaligned |
| store_i | input | 1 | Data access is a write |
| fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| small_pages_i | input | 1 | 1 KB page support enabled |
| tlb_lookup_o | output | 1 | Lookup request to the buffer |
| tlb_vpn_o | output | 21 | Lookup page number |
| tlb_asid_o | output | 8 | Lookup ASID |
| tlb_hit_i | input | 1 | Buffer has a matching entry |
| tlb_mask_i | input | 16 | Page mask of the matching entry |
| tlb_pfn_even_i | input | 20 | Even-page frame number |
| tlb_pfn_odd_i | input | 20 | Odd-page frame number |
| tlb_dirty_even_i | input | 1 | Even page writable |
| tlb_dirty_odd_i | input | 1 | Odd page writable |
| tlb_valid_even_i | input | 1 | Even page valid |
| tlb_valid_odd_i | input | 1 | Odd page valid |
| pa_o | output | 32 | Physical address |
| uncached_o | output | 1 | Access bypasses caches |
| fault_o | output | 3 | Fault code |
| bad_vaddr_o | output | 32 | Captured faulting address |
| flt_asid_o | output | 8 | Captured ASID |
| flt_vpn2_o | output | 19 | Captured page-pair number |
| flt_vpn2x_o | output | 2 | Captured sub-pair bits |
| ctx_badvpn2_o | output | 19 | Page-pair number for the context register |

## Verification
Each output is a pure function of the previous cycle's inputs. A wrong internal decision therefore shows at the ports one clock after the vector that provokes it, and only on that vector. A miscounted page shift appears as the wrong half being selected or the wrong offset bits being merged, so the bench concentrates on vectors that straddle the shift bit under masks of every width. A wrong fault priority or segment decode appears as a wrong fault code. It also shows as capture fields that are loaded or left at zero in the wrong places.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    FLT_NONE          = 3'd0,
    FLT_ADDR_FETCH    = 3'd1,
    FLT_ADDR_DATA     = 3'd2,
    FLT_REFILL_FETCH  = 3'd3,
    FLT_REFILL_DATA   = 3'd4,
    FLT_INVALID_FETCH = 3'd5,
    FLT_INVALID_DATA  = 3'd6,
    FLT_MODIFIED      = 3'd7
  } fault_e;

  typedef enum logic [1:0] {
    SEG_MAPPED      = 2'd0,
    SEG_DIRECT_CHK  = 2'd1,
    SEG_DIRECT_FREE = 2'd2
  } seg_e;

  localparam int unsigned BASE_SHIFT = 12;
endpackage

// File: rtl/xlat_seg_dec.sv
module xlat_seg_dec
  import xlat_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] va_i,
  output seg_e            seg_o,
  output logic [VA_W-1:0] direct_pa_o,
  output logic            uncached_o
);
  localparam int TOP_W = 3;

  logic [TOP_W-1:0] top;
  assign top = va_i[VA_W-1 -: TOP_W];

  always_comb begin
    case (top)
      3'b100:  seg_o = SEG_DIRECT_CHK;
      3'b101:  seg_o = SEG_DIRECT_FREE;
      default: seg_o = SEG_MAPPED;
    endcase
  end

  assign direct_pa_o = {{TOP_W{1'b0}}, va_i[VA_W-TOP_W-1:0]};
  assign uncached_o  = top[2] & top[0];
endmodule

// File: rtl/xlat_page_geom.sv
module xlat_page_geom
  import xlat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int PFN_W  = 20,
  parameter int MASK_W = 16
) (
  input  logic [VA_W-1:0]        va_i,
  input  logic [MASK_W-1:0]      mask_i,
  input  logic [PFN_W-1:0]       pfn_even_i,
  input  logic [PFN_W-1:0]       pfn_odd_i,
  input  logic                   dirty_even_i,
  input  logic                   dirty_odd_i,
  input  logic                   valid_even_i,
  input  logic                   valid_odd_i,
  output logic                   sel_valid_o,
  output logic                   sel_dirty_o,
  output logic [PFN_W+BASE_SHIFT-1:0] pa_o
);
  localparam int PA_W = PFN_W + BASE_SHIFT;
  localparam int SH_W = $clog2(BASE_SHIFT + MASK_W + 1);

  logic [SH_W-1:0] extra;
  logic [SH_W-1:0] shift;
  logic            odd_sel;
  logic [PFN_W-1:0] pfn_sel;
  logic [PA_W-1:0] off_mask;
  logic [PA_W-1:0] frame_base;

  // mask is contiguous from bit 0: popcount gives the extra page bits
  always_comb begin
    extra = '0;
    for (int k = 0; k < MASK_W; k++) extra = extra + SH_W'(mask_i[k]);
  end

  assign shift   = SH_W'(BASE_SHIFT) + extra;
  assign odd_sel = va_i[shift];

  assign pfn_sel     = odd_sel ? pfn_odd_i    : pfn_even_i;
  assign sel_valid_o = odd_sel ? valid_odd_i  : valid_even_i;
  assign sel_dirty_o = odd_sel ? dirty_odd_i  : dirty_even_i;

  assign off_mask   = ~({PA_W{1'b1}} << shift);
  assign frame_base = (PA_W'(pfn_sel) >> extra) << shift;
  assign pa_o       = frame_base | (PA_W'(va_i) & off_mask);
endmodule

// File: rtl/xlat_fault_cls.sv
module xlat_fault_cls
  import xlat_pkg::*;
(
  input  seg_e   seg_i,
  input  logic   kernel_i,
  input  logic   misaligned_i,
  input  logic   fetch_i,
  input  logic   store_i,
  input  logic   hit_i,
  input  logic   sel_valid_i,
  input  logic   sel_dirty_i,
  output fault_e fault_o
);
  fault_e addr_err;
  assign addr_err = fetch_i ? FLT_ADDR_FETCH : FLT_ADDR_DATA;

  always_comb begin
    fault_o = FLT_NONE;
    case (seg_i)
      SEG_DIRECT_CHK: begin
        if (!kernel_i || misaligned_i) fault_o = addr_err;
      end
      SEG_DIRECT_FREE: fault_o = FLT_NONE;
      default: begin
        if (misaligned_i)                         fault_o = addr_err;
        else if (!hit_i)                          fault_o = fetch_i ? FLT_REFILL_FETCH : FLT_REFILL_DATA;
        else if (!sel_valid_i)                    fault_o = fetch_i ? FLT_INVALID_FETCH : FLT_INVALID_DATA;
        else if (!fetch_i && store_i && !sel_dirty_i) fault_o = FLT_MODIFIED;
        else                                      fault_o = FLT_NONE;
      end
    endcase
  end
endmodule

// File: rtl/xlat_fault_unit.sv
module xlat_fault_unit
  import xlat_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  parameter int MASK_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [VA_W-1:0]      va_i,
  input  logic [ASID_W-1:0]    asid_i,
  input  logic                 kernel_i,
  input  logic                 misaligned_i,
  input  logic                 store_i,
  input  logic                 fetch_i,
  input  logic                 small_pages_i,
  output logic                 tlb_lookup_o,
  output logic [VA_W-12:0]     tlb_vpn_o,
  output logic [ASID_W-1:0]    tlb_asid_o,
  input  logic                 tlb_hit_i,
  input  logic [MASK_W-1:0]    tlb_mask_i,
  input  logic [PFN_W-1:0]     tlb_pfn_even_i,
  input  logic [PFN_W-1:0]     tlb_pfn_odd_i,
  input  logic                 tlb_dirty_even_i,
  input  logic                 tlb_dirty_odd_i,
  input  logic                 tlb_valid_even_i,
  input  logic                 tlb_valid_odd_i,
  output logic [PFN_W+11:0]    pa_o,
  output logic                 uncached_o,
  output logic [2:0]           fault_o,
  output logic [VA_W-1:0]      bad_vaddr_o,
  output logic [ASID_W-1:0]    flt_asid_o,
  output logic [VA_W-14:0]     flt_vpn2_o,
  output logic [1:0]           flt_vpn2x_o,
  output logic [VA_W-14:0]     ctx_badvpn2_o
);
  localparam int PA_W   = PFN_W + BASE_SHIFT;
  localparam int VPN_W  = VA_W - 11;
  localparam int VPN2_W = VPN_W - 2;

  seg_e            seg;
  logic [VA_W-1:0] direct_pa;
  logic            seg_uncached;
  logic            sel_valid;
  logic            sel_dirty;
  logic [PA_W-1:0] page_pa;
  fault_e          fault_c;
  logic [VPN_W-1:0] vpn;

  xlat_seg_dec #(.VA_W(VA_W)) u_seg (
    .va_i        (va_i),
    .seg_o       (seg),
    .direct_pa_o (direct_pa),
    .uncached_o  (seg_uncached)
  );

  xlat_page_geom #(.VA_W(VA_W), .PFN_W(PFN_W), .MASK_W(MASK_W)) u_geom (
    .va_i         (va_i),
    .mask_i       (tlb_mask_i),
    .pfn_even_i   (tlb_pfn_even_i),
    .pfn_odd_i    (tlb_pfn_odd_i),
    .dirty_even_i (tlb_dirty_even_i),
    .dirty_odd_i  (tlb_dirty_odd_i),
    .valid_even_i (tlb_valid_even_i),
    .valid_odd_i  (tlb_valid_odd_i),
    .sel_valid_o  (sel_valid),
    .sel_dirty_o  (sel_dirty),
    .pa_o         (page_pa)
  );

  xlat_fault_cls u_cls (
    .seg_i        (seg),
    .kernel_i     (kernel_i),
    .misaligned_i (misaligned_i),
    .fetch_i      (fetch_i),
    .store_i      (store_i),
    .hit_i        (tlb_hit_i),
    .sel_valid_i  (sel_valid),
    .sel_dirty_i  (sel_dirty),
    .fault_o      (fault_c)
  );

  // lookup port
  assign vpn          = small_pages_i ? va_i[VA_W-1:11] : {va_i[VA_W-1:13], 2'b00};
  assign tlb_vpn_o    = vpn;
  assign tlb_asid_o   = asid_i;
  assign tlb_lookup_o = (seg == SEG_MAPPED);

  // next-state values
  logic              has_fault, tlb_fault;
  logic [PA_W-1:0]   pa_d;
  logic              unc_d;
  logic [VA_W-1:0]   bad_d;
  logic [ASID_W-1:0] asid_d;
  logic [VPN2_W-1:0] vpn2_d;
  logic [1:0]        vpn2x_d;

  always_comb begin
    has_fault = (fault_c != FLT_NONE);
    tlb_fault = (fault_c >= FLT_REFILL_FETCH);
    if (has_fault)              pa_d = '0;
    else if (seg == SEG_MAPPED) pa_d = page_pa;
    else                        pa_d = PA_W'(direct_pa);
    unc_d   = !has_fault && seg_uncached;
    bad_d   = has_fault ? va_i : '0;
    asid_d  = tlb_fault ? asid_i : '0;
    vpn2_d  = tlb_fault ? vpn[VPN_W-1:2] : '0;
    vpn2x_d = tlb_fault ? vpn[1:0] : 2'b00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pa_o          <= '0;
      uncached_o    <= 1'b0;
      fault_o       <= FLT_NONE;
      bad_vaddr_o   <= '0;
      flt_asid_o    <= '0;
      flt_vpn2_o    <= '0;
      flt_vpn2x_o   <= 2'b00;
      ctx_badvpn2_o <= '0;
    end else begin
      pa_o          <= pa_d;
      uncached_o    <= unc_d;
      fault_o       <= fault_c;
      bad_vaddr_o   <= bad_d;
      flt_asid_o    <= asid_d;
      flt_vpn2_o    <= vpn2_d;
      flt_vpn2x_o   <= vpn2x_d;
      ctx_badvpn2_o <= vpn2_d;
    end
  end

  // assertions
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_no_lookup_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (va_i[VA_W-1 -: 2] == 2'b10) |-> !tlb_lookup_o);

  a_r2_user_direct_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(va_i[VA_W-1 -: 3] == 3'b100 && !kernel_i))
    |-> (fault_o == FLT_ADDR_FETCH || fault_o == FLT_ADDR_DATA));

  a_r3_free_direct_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(va_i[VA_W-1 -: 3] == 3'b101)) |-> (fault_o == FLT_NONE && uncached_o));

  a_r5_misaligned_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(misaligned_i && va_i[VA_W-1 -: 2] != 2'b10))
    |-> (fault_o == FLT_ADDR_FETCH || fault_o == FLT_ADDR_DATA));

  a_r8_modified_store_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && fault_o == FLT_MODIFIED) |-> $past(store_i && !fetch_i && tlb_hit_i));

  a_r10_uncached_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && uncached_o) |-> (fault_o == FLT_NONE && $past(va_i[VA_W-1] && va_i[VA_W-3])));

  a_r11_capture_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && fault_o >= FLT_REFILL_FETCH)
    |-> (flt_vpn2_o == ctx_badvpn2_o && bad_vaddr_o == $past(va_i)));

  a_r11_quiet_no_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o == FLT_NONE) |-> (bad_vaddr_o == '0 && flt_asid_o == '0 && flt_vpn2x_o == 2'b00));

  a_r9_no_pa_on_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_o != FLT_NONE) |-> (pa_o == '0 && !uncached_o));
endmodule

// File: tb/xlat_fault_unit_bench.sv
module xlat_fault_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] va_i = '0;
  logic [7:0]  asid_i = '0;
  logic        kernel_i = 1'b0, misaligned_i = 1'b0, store_i = 1'b0, fetch_i = 1'b0, small_pages_i = 1'b0;
  logic        tlb_lookup_o;
  logic [20:0] tlb_vpn_o;
  logic [7:0]  tlb_asid_o;
  logic        tlb_hit_i = 1'b0;
  logic [15:0] tlb_mask_i = '0;
  logic [19:0] tlb_pfn_even_i = '0, tlb_pfn_odd_i = '0;
  logic        tlb_dirty_even_i = 1'b0, tlb_dirty_odd_i = 1'b0;
  logic        tlb_valid_even_i = 1'b0, tlb_valid_odd_i = 1'b0;
  logic [31:0] pa_o;
  logic        uncached_o;
  logic [2:0]  fault_o;
  logic [31:0] bad_vaddr_o;
  logic [7:0]  flt_asid_o;
  logic [18:0] flt_vpn2_o;
  logic [1:0]  flt_vpn2x_o;
  logic [18:0] ctx_badvpn2_o;

  always #4 clk_i = ~clk_i;

  xlat_fault_unit u_xlat_fault_unit (
    .clk_i, .rst_ni, .va_i, .asid_i, .kernel_i, .misaligned_i, .store_i, .fetch_i,
    .small_pages_i, .tlb_lookup_o, .tlb_vpn_o, .tlb_asid_o, .tlb_hit_i, .tlb_mask_i,
    .tlb_pfn_even_i, .tlb_pfn_odd_i, .tlb_dirty_even_i, .tlb_dirty_odd_i,
    .tlb_valid_even_i, .tlb_valid_odd_i, .pa_o, .uncached_o, .fault_o, .bad_vaddr_o,
    .flt_asid_o, .flt_vpn2_o, .flt_vpn2x_o, .ctx_badvpn2_o
  );

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // expected values
  logic        e_lookup;
  logic [20:0] e_vpn;
  logic [31:0] e_pa, e_bad;
  logic        e_unc;
  logic [2:0]  e_fault;
  logic [7:0]  e_asid;
  logic [18:0] e_vpn2;
  logic [1:0]  e_vpn2x;
  string       e_tag;

  task automatic model();
    int sh;
    bit odd, v, d;
    longint unsigned pfn, offm, pa;
    e_lookup = (va_i[31:30] != 2'b10);
    e_vpn    = small_pages_i ? va_i[31:11] : {va_i[31:13], 2'b00};
    sh = 12;
    for (int k = 0; k < 16; k++) if (tlb_mask_i[k]) sh++;
    odd = va_i[sh];
    v   = odd ? tlb_valid_odd_i : tlb_valid_even_i;
    d   = odd ? tlb_dirty_odd_i : tlb_dirty_even_i;
    pfn = odd ? tlb_pfn_odd_i : tlb_pfn_even_i;
    offm = (64'd1 << sh) - 1;
    pa = ((pfn << 12) & ~offm) | (longint'(va_i) & offm);
    if (va_i[31:29] == 3'b100) begin
      e_tag = "R2";
      e_fault = (!kernel_i || misaligned_i) ? (fetch_i ? 3'd1 : 3'd2) : 3'd0;
      e_pa = va_i & 32'h1FFF_FFFF;
    end else if (va_i[31:29] == 3'b101) begin
      e_tag = "R3";
      e_fault = 3'd0;
      e_pa = va_i & 32'h1FFF_FFFF;
    end else begin
      e_pa = pa[31:0];
      if (misaligned_i) begin e_tag = "R5"; e_fault = fetch_i ? 3'd1 : 3'd2; end
      else if (!tlb_hit_i) begin e_tag = "R7"; e_fault = fetch_i ? 3'd3 : 3'd4; end
      else if (!v) begin e_tag = "R6"; e_fault = fetch_i ? 3'd5 : 3'd6; end
      else if (!fetch_i && store_i && !d) begin e_tag = "R8"; e_fault = 3'd7; end
      else begin e_tag = "R9"; e_fault = 3'd0; end
    end
    if (e_fault != 0) e_pa = '0;
    e_unc = (e_fault == 0) && va_i[31] && va_i[29];
    e_bad = (e_fault != 0) ? va_i : '0;
    if (e_fault >= 3) begin
      e_asid = asid_i; e_vpn2 = e_vpn[20:2]; e_vpn2x = e_vpn[1:0];
    end else begin
      e_asid = '0; e_vpn2 = '0; e_vpn2x = 2'b00;
    end
  endtask

  task automatic apply(input logic [31:0] va, input logic [7:0] asid, input bit kern, input bit mis,
                       input bit st, input bit fe, input bit sp, input bit hit, input logic [15:0] mask,
                       input logic [19:0] pe, input logic [19:0] po, input bit de, input bit dodd,
                       input bit ve, input bit vo);
    va_i = va; asid_i = asid; kernel_i = kern; misaligned_i = mis; store_i = st; fetch_i = fe;
    small_pages_i = sp; tlb_hit_i = hit; tlb_mask_i = mask; tlb_pfn_even_i = pe; tlb_pfn_odd_i = po;
    tlb_dirty_even_i = de; tlb_dirty_odd_i = dodd; tlb_valid_even_i = ve; tlb_valid_odd_i = vo;
    #1;
    model();
    chk("R1", "lookup", 64'(tlb_lookup_o), 64'(e_lookup));
    chk("R1", "vpn", 64'(tlb_vpn_o), 64'(e_vpn));
    chk("R1", "asid", 64'(tlb_asid_o), 64'(asid));
    @(posedge clk_i);
    @(negedge clk_i);
    chk(e_tag, "fault R4", 64'(fault_o), 64'(e_fault));
    chk(e_tag, "pa R9", 64'(pa_o), 64'(e_pa));
    chk("R10", "uncached", 64'(uncached_o), 64'(e_unc));
    chk("R11", "bad_vaddr", 64'(bad_vaddr_o), 64'(e_bad));
    chk("R11", "asid", 64'(flt_asid_o), 64'(e_asid));
    chk("R11", "vpn2", 64'(flt_vpn2_o), 64'(e_vpn2));
    chk("R11", "vpn2x", 64'(flt_vpn2x_o), 64'(e_vpn2x));
    chk("R11", "ctx", 64'(ctx_badvpn2_o), 64'(e_vpn2));
  endtask

  initial begin
    void'($urandom(32'd2024));
    #20;
    // R12 reset state
    chk("R12", "pa reset", 64'(pa_o), 64'd0);
    chk("R12", "fault reset", 64'(fault_o), 64'd0);
    chk("R12", "bad reset", 64'(bad_vaddr_o), 64'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R2 direct kernel window
    apply(32'h8123_4567, 8'h11, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    apply(32'h8000_0040, 8'h11, 0, 0, 0, 1, 0, 1, 0, 0, 0, 1, 1, 1, 1);
    apply(32'h9FFF_FFFC, 8'h22, 1, 1, 1, 0, 0, 1, 0, 0, 0, 1, 1, 1, 1);
    // R3 free window, user and misaligned
    apply(32'hA000_1000, 8'h33, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R5 misaligned beats refill
    apply(32'h0040_0003, 8'h44, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 refill fetch with capture
    apply(32'h1234_5678, 8'h55, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    // R6 mask 0, odd half via bit 12
    apply(32'h0000_3ABC, 8'h01, 0, 0, 1, 0, 0, 1, 16'h0, 20'hAAAAA, 20'h55555, 0, 1, 0, 1);
    apply(32'h0000_3ABC, 8'h01, 0, 0, 0, 0, 0, 1, 16'h0, 20'hAAAAA, 20'h55555, 1, 1, 1, 0);
    // R6 widest mask, bit 28
    apply(32'h1FFF_1234, 8'h02, 0, 0, 0, 1, 0, 1, 16'hFFFF, 20'h12345, 20'hF0000, 1, 1, 0, 1);
    // R8 store vs load vs fetch on clean page
    apply(32'h0040_2000, 8'h03, 0, 0, 1, 0, 0, 1, 16'h3, 20'h00ABC, 20'h00DEF, 0, 0, 1, 1);
    apply(32'h0040_2000, 8'h03, 0, 0, 0, 0, 0, 1, 16'h3, 20'h00ABC, 20'h00DEF, 0, 0, 1, 1);
    apply(32'h0040_2000, 8'h03, 0, 0, 1, 1, 0, 1, 16'h3, 20'h00ABC, 20'h00DEF, 0, 0, 1, 1);
    // R1 small pages keep low vpn bits in capture
    apply(32'h0000_1800, 8'h04, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R10 mapped high region marked uncached
    apply(32'hE000_0100, 8'h05, 1, 0, 0, 0, 0, 1, 16'h0, 20'hCAFE0, 20'hBEEF0, 1, 1, 1, 1);
    // random
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] va;
      int k;
      va = $urandom;
      k = $urandom % 17;
      if (($urandom % 4) == 0) va[31:30] = 2'b10;
      apply(va, 8'($urandom), 1'($urandom), (($urandom % 8) == 0), 1'($urandom), 1'($urandom),
            (($urandom % 4) == 0), (($urandom % 5) != 0), 16'((32'd1 << k) - 1),
            20'($urandom), 20'($urandom), 1'($urandom), 1'($urandom),
            (($urandom % 4) != 0), (($urandom % 4) != 0));
    end
    // R12 async reset clears outputs
    apply(32'h1234_5678, 8'h55, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    rst_ni = 1'b0;
    #1;
    chk("R12", "fault after reset", 64'(fault_o), 64'd0);
    chk("R12", "bad after reset", 64'(bad_vaddr_o), 64'd0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule